// File: doc/BRIEF.md
# Electronic Dice Pip Sequencer

This block is the core of an electronic die. It runs on a free-running clock. While the roll input is high it moves to the next face on every clock edge. When the roll input drops, it stops on whatever face it has reached, and that face is the result of the throw. Because the clock runs much faster than a person can press a button, the result is unpredictable.

The state is not a binary count. It is the pip pattern itself, held in four flip-flops:

- One toggle bit lights the centre pip.
- Three pair bits each light two outer pips at once. These bits fill up in order, like a thermometer.

The display lines come straight from these bits, so there is no decoder. A face value output (1 to 6) is also given, for logging and test. It equals the number of lit pips. If the state bits ever hold a combination outside the six legal faces, the block returns to face 1 on the next clock.

Top module: `dice_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block takes face 1 on that edge, even if `roll_en` is high. Face 1 means `pip_o` = 7'b0000001 and `face_o` = 1.
- R2: When `roll_en` is low at a clock edge, `pip_o` and `face_o` keep their values across that edge.
- R3: When `roll_en` is high at a clock edge, the face moves up by one on that edge.
- R4: A rolling edge taken while showing face 6 gives face 1. On that edge all pair pips go dark together and the centre pip lights.
- R5: The centre pip is `pip_o[0]`. It changes state on every rolling edge.
- R6: Pair k drives `pip_o[2k+1]` and `pip_o[2k+2]`, with k from 0 to 2. Both pips of a pair are always equal. A pair is lit only if every lower-numbered pair is lit.
- R7: A pair pip that was dark becomes lit only on an edge where the centre pip goes from lit to dark.
- R8: `face_o` always lies in the range 1 to 6 and equals the number of lit bits in `pip_o`. Odd faces have the centre lit. Face 6 is all three pairs lit with the centre dark.
- R9: The centre pip and all three pairs are never lit at the same time, so there is never a seventh state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to face 1 |
| roll_en | input | 1 | High: advance one face per clock. Low: hold the current face |
| pip_o | output | 7 | Pip lines. Bit 0 is the centre; bits 2k+1 and 2k+2 are pair k |
| face_o | output | 3 | Face shown, from 1 to 6 |

## Verification
The bench drives the block with four kinds of input pattern:

- **Long unbroken roll.** This passes the wrap twice and checks that every face appears in order. It would expose a skipped face, a seventh state, or a wrap that clears only some of the pairs.
- **Sparse and stuttering roll.** Single-cycle pulses and irregular on/off patterns separate a correct hold from a block that advances whenever the clock runs. They also check that the face reached after a pause is correct.
- **Parking on face 6.** The bench stops on face 6 and then rolls once, which tests the wrap on its own.
- **Reset with roll held high.** This shows that reset takes priority over rolling.

// File: rtl/dice_pkg.sv
`timescale 1ns/1ps
package dice_pkg;

    localparam int unsigned DIE_PAIRS = 3;
    localparam int unsigned DIE_FACES = 2 * DIE_PAIRS;
    localparam int unsigned DIE_PIPS  = 2 * DIE_PAIRS + 1;
    localparam int unsigned FACE_W    = $clog2(DIE_FACES + 1);

    localparam logic [DIE_PAIRS-1:0] PAIR_ONE = DIE_PAIRS'(1);

    // Pip state: a thermometer of pairs plus the centre toggle bit.
    typedef struct packed {
        logic [DIE_PAIRS-1:0] pairs;
        logic                 centre;
    } die_state_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LIGHT_CENTRE,
        ACT_FILL_PAIR,
        ACT_WRAP,
        ACT_RECOVER
    } die_action_t;

    localparam die_state_t DIE_FACE_ONE = '{pairs: '0, centre: 1'b1};

    // True when the set pair bits form a contiguous run starting at pair 0.
    function automatic logic is_thermo(input logic [DIE_PAIRS-1:0] p);
        return ((p + PAIR_ONE) & p) == '0;
    endfunction

    function automatic logic is_legal(input die_state_t s);
        return is_thermo(s.pairs) && !(s.centre && (&s.pairs));
    endfunction

    function automatic logic [FACE_W-1:0] count_pairs(input logic [DIE_PAIRS-1:0] p);
        logic [FACE_W-1:0] c;
        c = '0;
        for (int i = 0; i < DIE_PAIRS; i++) begin
            c = c + FACE_W'(p[i]);
        end
        return c;
    endfunction

    function automatic logic [FACE_W-1:0] face_value(input die_state_t s);
        logic [FACE_W-1:0] n;
        n = count_pairs(s.pairs);
        return n + n + FACE_W'(s.centre);
    endfunction

endpackage

// File: rtl/dice_step_ctrl.sv
`timescale 1ns/1ps
module dice_step_ctrl
    import dice_pkg::*;
(
    input  die_state_t  state_i,
    input  logic        roll_en,
    output die_action_t action_o
);

    always_comb begin
        if (!is_legal(state_i)) begin
            action_o = ACT_RECOVER;
        end else if (!roll_en) begin
            action_o = ACT_HOLD;
        end else if (state_i.centre) begin
            action_o = ACT_FILL_PAIR;   // centre falls, next pair fills
        end else if (&state_i.pairs) begin
            action_o = ACT_WRAP;        // last face reached
        end else begin
            action_o = ACT_LIGHT_CENTRE;
        end
    end

endmodule

// File: rtl/dice_state_reg.sv
`timescale 1ns/1ps
module dice_state_reg
    import dice_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  die_action_t action_i,
    output die_state_t  state_o
);

    die_state_t state_q;
    die_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (action_i)
            ACT_HOLD: state_d = state_q;
            ACT_LIGHT_CENTRE: state_d.centre = 1'b1;
            ACT_FILL_PAIR: begin
                state_d.centre = 1'b0;
                state_d.pairs  = (state_q.pairs << 1) | PAIR_ONE;
            end
            ACT_WRAP:    state_d = DIE_FACE_ONE;
            ACT_RECOVER: state_d = DIE_FACE_ONE;
            default:     state_d = DIE_FACE_ONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIE_FACE_ONE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R6: pairs stay a contiguous run from pair 0
    a_r6_thermometer: assert property (@(posedge clk) disable iff (rst)
        is_thermo(state_q.pairs));

    // R9: centre and every pair never lit together
    a_r9_no_seventh: assert property (@(posedge clk) disable iff (rst)
        !(state_q.centre && (&state_q.pairs)));

    // R7: a newly set pair coincides with the centre falling
    a_r7_fill_on_fall: assert property (@(posedge clk) disable iff (rst)
        (|(state_q.pairs & ~$past(state_q.pairs))) |-> ($past(state_q.centre) && !state_q.centre));

endmodule

// File: rtl/dice_pip_driver.sv
`timescale 1ns/1ps
module dice_pip_driver
    import dice_pkg::*;
(
    input  die_state_t          state_i,
    output logic [DIE_PIPS-1:0] pip_o,
    output logic [FACE_W-1:0]   face_o
);

    assign pip_o[0] = state_i.centre;

    for (genvar k = 0; k < DIE_PAIRS; k++) begin : g_pair
        assign pip_o[2*k+1] = state_i.pairs[k];
        assign pip_o[2*k+2] = state_i.pairs[k];
    end

    assign face_o = face_value(state_i);

endmodule

// File: rtl/dice_sequencer.sv
`timescale 1ns/1ps
module dice_sequencer
    import dice_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                roll_en,
    output logic [DIE_PIPS-1:0] pip_o,
    output logic [FACE_W-1:0]   face_o
);

    die_state_t  state;
    die_action_t action;

    dice_step_ctrl u_ctrl (
        .state_i  (state),
        .roll_en  (roll_en),
        .action_o (action)
    );

    dice_state_reg u_state (
        .clk      (clk),
        .rst      (rst),
        .action_i (action),
        .state_o  (state)
    );

    dice_pip_driver u_pips (
        .state_i (state),
        .pip_o   (pip_o),
        .face_o  (face_o)
    );

    // R2: no roll, no change on the display
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !roll_en |=> ($stable(pip_o) && $stable(face_o)));

    // R5: centre pip flips on each rolling edge
    a_r5_centre_toggle: assert property (@(posedge clk) disable iff (rst)
        roll_en |=> (pip_o[0] != $past(pip_o[0])));

    // R4: rolling from the top face lands on face 1
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (roll_en && face_o == FACE_W'(DIE_FACES)) |=> (face_o == FACE_W'(1)));

    // R8: face value equals the lit pip count and stays in range
    a_r8_face_count: assert property (@(posedge clk) disable iff (rst)
        (int'(face_o) == $countones(pip_o)) && face_o != '0
        && face_o <= FACE_W'(DIE_FACES));

endmodule

// File: tb/dice_sequencer_tb.sv
`timescale 1ns/1ps
module dice_sequencer_tb;
    import dice_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                roll_en = 1'b0;
    logic [DIE_PIPS-1:0] pip_o;
    logic [FACE_W-1:0]   face_o;

    int checks = 0;
    int errors = 0;
    int model_face = 1;

    typedef struct {
        int                  face;
        logic [DIE_PIPS-1:0] pips;
        string               tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    dice_sequencer u_dut (
        .clk     (clk),
        .rst     (rst),
        .roll_en (roll_en),
        .pip_o   (pip_o),
        .face_o  (face_o)
    );

    function automatic logic [DIE_PIPS-1:0] pips_for(input int f);
        logic [DIE_PIPS-1:0] p;
        p = '0;
        p[0] = f[0];
        for (int k = 0; k < f / 2; k++) begin
            p[2*k+1] = 1'b1;
            p[2*k+2] = 1'b1;
        end
        return p;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outcome.
    task automatic drive(input logic r, input logic en, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r;
        roll_en = en;
        if (r) model_face = 1;
        else if (en) model_face = (model_face == DIE_FACES) ? 1 : model_face + 1;
        e.face = model_face;
        e.pips = pips_for(model_face);
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares outputs just after each edge.
    logic [DIE_PIPS-1:0] prev_pips;
    bit                  prev_valid = 0;

    always @(posedge clk) begin : mon
        exp_t e;
        logic [DIE_PIPS-1:0] newly;
        bit pair_ok;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(int'(face_o) == e.face, e.tag, "face", int'(face_o), e.face);
            chk(pip_o == e.pips, e.tag, "pips", int'(pip_o), int'(e.pips));
            chk(int'(face_o) == $countones(pip_o), "R8", "face vs lit count",
                int'(face_o), $countones(pip_o));
            chk(!(pip_o[0] && (&pip_o[DIE_PIPS-1:1])), "R9", "seventh state",
                int'(pip_o), 0);
            pair_ok = 1;
            for (int k = 0; k < DIE_PAIRS; k++) begin
                if (pip_o[2*k+1] != pip_o[2*k+2]) pair_ok = 0;
                if (k > 0 && pip_o[2*k+1] && !pip_o[2*k-1]) pair_ok = 0;
            end
            chk(pair_ok, "R6", "pair order", int'(pip_o), int'(e.pips));
            if (prev_valid && !rst) begin
                if (roll_en) begin
                    chk(pip_o[0] != prev_pips[0], "R5", "centre toggle",
                        int'(pip_o[0]), int'(!prev_pips[0]));
                end
                newly = pip_o & ~prev_pips;
                newly[0] = 1'b0;
                if (newly != '0) begin
                    chk(prev_pips[0] && !pip_o[0], "R7", "fill without centre fall",
                        int'({prev_pips[0], pip_o[0]}), 2);
                end
            end
            prev_pips  = pip_o;
            prev_valid = 1;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) drive(1'b1, 1'b0, "R1");
        repeat (3) drive(1'b0, 1'b0, "R2");
        drive(1'b0, 1'b1, "R3");
        repeat (2) drive(1'b0, 1'b0, "R2");
        repeat (14) drive(1'b0, 1'b1, "R3/R4");
        for (int i = 0; i < 12; i++) begin
            drive(1'b0, (i % 3) != 0, "R2/R3");
        end
        while (model_face != DIE_FACES) drive(1'b0, 1'b1, "R3");
        repeat (2) drive(1'b0, 1'b0, "R2");
        drive(1'b0, 1'b1, "R4");
        repeat (3) drive(1'b0, 1'b1, "R3");
        drive(1'b1, 1'b1, "R1");
        drive(1'b0, 1'b0, "R1");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule